// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit performs one atomic memory operation at a time on behalf of a requester. A request carries a 5-bit function code, a kind bit that selects fetching or store behaviour, an operand width of 32 or 64 bits, a byte address and two data operands. The unit reads one word, or two neighbouring words, through a synchronous memory port with one cycle of read latency. It then works out the new memory value and decides whether to write it. Finally it raises a one-cycle completion pulse. Fetching requests carry a result value with the pulse. Store requests return zero.

A new request is accepted only while the unit is idle. Requests therefore never overlap and never reorder, and every operation is complete before the next one starts. The operand that a fetching operation combines with memory is `reqOpA`. Compare-and-swap-not-equal also uses `reqOpB` as the replacement value. A store request takes its source value from `reqOpA`.

Top module: `amo_unit`

## Requirements
- R1: After reset `reqReady` is 1 and `rspValid` is 0. `reqReady` falls in the cycle after a request is accepted and stays low until that request has completed.
- R2: Fetching codes 0–7 (0 add, 1 xor, 2 or, 3 and, 4 unsigned max, 5 signed max, 6 unsigned min, 7 signed min) return the old word at the address and write op(old, `reqOpA`) there.
- R3: Fetching code 8 (swap) returns the old word and writes `reqOpA`.
- R4: When `reqWide`=0, operations use the low 32 bits. Signs come from bit 31, and both results and stored words are zero-extended to 64 bits.
- R5: Fetching code 16 (compare-and-swap-not-equal) returns the old word. It writes `reqOpB` only when the old word differs from `reqOpA`.
- R6: Fetching code 24 (increment bounded) reads the words at the address and at the address plus the size. When they differ it writes old+1 and returns old. Otherwise it writes nothing and returns a word with only the operand's sign bit set.
- R7: Fetching code 25 (increment equal) behaves like R6, except that it succeeds only when the two words are equal.
- R8: Fetching code 28 (decrement bounded) reads the words at the address minus the size and at the address. When they differ it writes old−1 at the address and returns old. Otherwise it returns the sign-bit word and writes nothing.
- R9: Store codes 0–7 apply the R2 operations with `reqOpA`, update memory and return zero.
- R10: Store code 24 (twin store) writes `reqOpA` to the address and to the address plus the size, but only when the two current words are equal. It returns zero.
- R11: Any other code completes with `rspErr`=1 and makes no memory read or write.
- R12: Each accepted request produces exactly one `rspValid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit idle, request accepted |
| reqStore | input | 1 | 1 = store kind, 0 = fetching kind |
| reqWide | input | 1 | 1 = 64-bit, 0 = 32-bit operands |
| reqFunc | input | 5 | Function code |
| reqAddr | input | ADDR_W | Byte address |
| reqOpA | input | DATA_W | Combining / source operand |
| reqOpB | input | DATA_W | Replacement value for compare-and-swap |
| rspValid | output | 1 | Completion pulse |
| rspErr | output | 1 | Unknown function code |
| rspData | output | DATA_W | Returned value |
| memRe | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memWide | output | 1 | Access width, 1 = 64-bit |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, one cycle after `memRe` |

## Verification
A wrong captured word or a wrong decode shows up at the ports within three to five cycles of acceptance. It appears as a wrong returned value or a wrong error flag with the completion pulse. It can also appear as a stray write, or a missing one, which the bench sees by comparing memory against its own model straight after each request. A state machine that loses its place shows up as `reqReady` staying low, as doubled completion pulses, or as a hung run.

// File: rtl/amo_pkg.sv
`timescale 1ns/1ps
package amo_pkg;
  typedef enum logic [2:0] {
    K_ALU, K_SWAP, K_CASNE, K_INCB, K_INCE, K_DECB, K_TWIN, K_BAD
  } opKind_e;

  typedef enum logic [1:0] { A_BASE, A_UP, A_DOWN } addrSel_e;

  typedef struct packed {
    logic     latchReq;
    logic     capFirst;
    logic     capSecond;
    logic     rdEn;
    logic     wrEn;
    addrSel_e addrSel;
    logic     finish;
  } strobe_t;

  function automatic opKind_e decodeKind(input logic isStore, input logic [4:0] fc);
    opKind_e k;
    k = K_BAD;
    if (fc[4:3] == 2'b00) k = K_ALU;
    else if (isStore) begin
      if (fc == 5'b11000) k = K_TWIN;
    end else begin
      case (fc)
        5'b01000: k = K_SWAP;
        5'b10000: k = K_CASNE;
        5'b11000: k = K_INCB;
        5'b11001: k = K_INCE;
        5'b11100: k = K_DECB;
        default:  k = K_BAD;
      endcase
    end
    return k;
  endfunction

  function automatic logic needsPair(input opKind_e k);
    return (k == K_INCB) || (k == K_INCE) || (k == K_DECB) || (k == K_TWIN);
  endfunction
endpackage

// File: rtl/amo_dpath.sv
`timescale 1ns/1ps
module amo_dpath
  import amo_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              reqStore,
  input  logic              reqWide,
  input  logic [4:0]        reqFunc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqOpA,
  input  logic [DATA_W-1:0] reqOpB,
  input  logic [DATA_W-1:0] memRdata,
  output opKind_e           kind,
  output logic              wrCond,
  output logic              wide,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr
);
  localparam int HALF_W  = DATA_W / 2;
  localparam int BYTES_F = DATA_W / 8;
  localparam int BYTES_H = HALF_W / 8;

  logic              isStore;
  logic [2:0]        aluOp;
  logic [ADDR_W-1:0] baseAddr;
  logic [DATA_W-1:0] opA, opB, wFirst, wSecond;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kind <= K_BAD; isStore <= 1'b0; wide <= 1'b0; aluOp <= '0;
      baseAddr <= '0; opA <= '0; opB <= '0; wFirst <= '0; wSecond <= '0;
    end else begin
      if (strobe.latchReq) begin
        kind     <= decodeKind(reqStore, reqFunc);
        isStore  <= reqStore;
        wide     <= reqWide;
        aluOp    <= reqFunc[2:0];
        baseAddr <= reqAddr;
        opA      <= reqOpA;
        opB      <= reqOpB;
      end
      if (strobe.capFirst)  wFirst  <= memRdata & sizeMask;
      if (strobe.capSecond) wSecond <= memRdata & sizeMask;
    end
  end

  logic [DATA_W-1:0] sizeMask, signWord, oldW, otherW, aM, bM, sOld, sA, aluOut, newVal;
  logic [ADDR_W-1:0] stepBytes;
  logic              ltU, ltS;

  always_comb begin
    sizeMask  = wide ? '1 : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    signWord  = wide ? {1'b1, {(DATA_W-1){1'b0}}} : (DATA_W'(1) << (HALF_W - 1));
    stepBytes = wide ? ADDR_W'(BYTES_F) : ADDR_W'(BYTES_H);
    oldW      = (kind == K_DECB) ? wSecond : wFirst;
    otherW    = (kind == K_DECB) ? wFirst : wSecond;
    aM        = opA & sizeMask;
    bM        = opB & sizeMask;
    sOld      = wide ? oldW : {{HALF_W{oldW[HALF_W-1]}}, oldW[HALF_W-1:0]};
    sA        = wide ? aM : {{HALF_W{aM[HALF_W-1]}}, aM[HALF_W-1:0]};
    ltU       = oldW < aM;
    ltS       = $signed(sOld) < $signed(sA);
    case (aluOp)
      3'd0:    aluOut = oldW + aM;
      3'd1:    aluOut = oldW ^ aM;
      3'd2:    aluOut = oldW | aM;
      3'd3:    aluOut = oldW & aM;
      3'd4:    aluOut = ltU ? aM : oldW;
      3'd5:    aluOut = ltS ? aM : oldW;
      3'd6:    aluOut = ltU ? oldW : aM;
      default: aluOut = ltS ? oldW : aM;
    endcase
    case (kind)
      K_ALU:          newVal = aluOut;
      K_SWAP, K_TWIN: newVal = aM;
      K_CASNE:        newVal = bM;
      K_INCB, K_INCE: newVal = oldW + DATA_W'(1);
      K_DECB:         newVal = oldW - DATA_W'(1);
      default:        newVal = '0;
    endcase
    case (kind)
      K_ALU, K_SWAP:  wrCond = 1'b1;
      K_CASNE:        wrCond = oldW != aM;
      K_INCB, K_DECB: wrCond = oldW != otherW;
      K_INCE:         wrCond = oldW == otherW;
      K_TWIN:         wrCond = wFirst == wSecond;
      default:        wrCond = 1'b0;
    endcase
    memWdata = newVal & sizeMask;
    case (strobe.addrSel)
      A_UP:    memAddr = baseAddr + stepBytes;
      A_DOWN:  memAddr = baseAddr - stepBytes;
      default: memAddr = baseAddr;
    endcase
    rspErr = (kind == K_BAD);
    if (isStore || rspErr) rspData = '0;
    else if ((kind == K_INCB || kind == K_INCE || kind == K_DECB) && !wrCond) rspData = signWord;
    else rspData = oldW;
  end

  a_r5_casne_match_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && kind == K_CASNE) |-> (wFirst != (opA & sizeMask)));
  a_r6_incb_needs_differ: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && kind == K_INCB) |-> (wFirst != wSecond));
  a_r7_ince_needs_equal: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && kind == K_INCE) |-> (wFirst == wSecond));
  a_r10_twin_needs_equal: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && kind == K_TWIN) |-> (wFirst == wSecond));
  a_r4_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !wide) |-> (memWdata[DATA_W-1:HALF_W] == '0));
endmodule

// File: rtl/amo_ctrl.sv
`timescale 1ns/1ps
module amo_ctrl
  import amo_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqStore,
  input  logic [4:0] reqFunc,
  input  opKind_e kind,
  input  logic    wrCond,
  input  logic    rspErr,
  output logic    reqReady,
  output logic    rspValid,
  output strobe_t strobe
);
  typedef enum logic [2:0] { S_IDLE, S_RDA, S_RDB, S_CAPB, S_EXEC, S_WR2, S_ERR } state_e;
  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    strobe.addrSel = A_BASE;
    nextState = state;
    reqReady  = 1'b0;
    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          nextState = (decodeKind(reqStore, reqFunc) == K_BAD) ? S_ERR : S_RDA;
        end
      end
      S_RDA: begin
        strobe.rdEn    = 1'b1;
        strobe.addrSel = (kind == K_DECB) ? A_DOWN : A_BASE;
        nextState      = S_RDB;
      end
      S_RDB: begin
        strobe.capFirst = 1'b1;
        if (needsPair(kind)) begin
          strobe.rdEn    = 1'b1;
          strobe.addrSel = (kind == K_DECB) ? A_BASE : A_UP;
          nextState      = S_CAPB;
        end else nextState = S_EXEC;
      end
      S_CAPB: begin
        strobe.capSecond = 1'b1;
        nextState        = S_EXEC;
      end
      S_EXEC: begin
        strobe.wrEn = wrCond;
        if (kind == K_TWIN && wrCond) nextState = S_WR2;
        else begin
          strobe.finish = 1'b1;
          nextState     = S_IDLE;
        end
      end
      S_WR2: begin
        strobe.wrEn    = 1'b1;
        strobe.addrSel = A_UP;
        strobe.finish  = 1'b1;
        nextState      = S_IDLE;
      end
      default: begin
        strobe.finish = 1'b1;
        nextState     = S_IDLE;
      end
    endcase
    rspValid = strobe.finish;
  end

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  a_r11_error_no_access: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (!strobe.wrEn && !strobe.rdEn && !$past(strobe.rdEn)));
  a_r1_read_write_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.rdEn && strobe.wrEn));
endmodule

// File: rtl/amo_unit.sv
`timescale 1ns/1ps
module amo_unit
  import amo_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqStore,
  input  logic              reqWide,
  input  logic [4:0]        reqFunc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqOpA,
  input  logic [DATA_W-1:0] reqOpB,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspData,
  output logic              memRe,
  output logic              memWe,
  output logic              memWide,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);
  strobe_t strobe;
  opKind_e kind;
  logic    wrCond;

  amo_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqFunc(reqFunc), .kind(kind), .wrCond(wrCond), .rspErr(rspErr),
    .reqReady(reqReady), .rspValid(rspValid), .strobe(strobe)
  );

  amo_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqStore(reqStore),
    .reqWide(reqWide), .reqFunc(reqFunc), .reqAddr(reqAddr), .reqOpA(reqOpA),
    .reqOpB(reqOpB), .memRdata(memRdata), .kind(kind), .wrCond(wrCond),
    .wide(memWide), .memAddr(memAddr), .memWdata(memWdata),
    .rspData(rspData), .rspErr(rspErr)
  );

  assign memRe = strobe.rdEn;
  assign memWe = strobe.wrEn;
endmodule

// File: tb/amo_unit_tb_top.sv
`timescale 1ns/1ps
module amo_unit_tb_top;
  logic        clk = 0, rstN = 0;
  logic        reqValid = 0, reqStore = 0, reqWide = 0;
  logic [4:0]  reqFunc = 0;
  logic [31:0] reqAddr = 0;
  logic [63:0] reqOpA = 0, reqOpB = 0;
  logic        reqReady, rspValid, rspErr, memRe, memWe, memWide;
  logic [63:0] rspData, memWdata, memRdata = 0;
  logic [31:0] memAddr;

  int checks = 0, errors = 0, pulses = 0, accepted = 0;
  bit finished = 0, prevRsp = 0;
  logic [64:0] expQ[$];
  string       tagQ[$];
  logic [63:0] dutMem[logic [31:0]];
  logic [63:0] refMem[logic [31:0]];

  always #5 clk = ~clk;

  amo_unit dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqStore(reqStore), .reqWide(reqWide), .reqFunc(reqFunc), .reqAddr(reqAddr),
    .reqOpA(reqOpA), .reqOpB(reqOpB), .rspValid(rspValid), .rspErr(rspErr),
    .rspData(rspData), .memRe(memRe), .memWe(memWe), .memWide(memWide),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (memRe) memRdata <= dutMem.exists(memAddr) ?
      (memWide ? dutMem[memAddr] : {32'b0, dutMem[memAddr][31:0]}) : 64'b0;
    if (memWe) dutMem[memAddr] = memWide ? memWdata : {32'b0, memWdata[31:0]};
  end

  task automatic chk(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (rspValid && prevRsp) chk(0, "R12 double pulse", 65'd1, 65'd0);
      if (rspValid) begin
        pulses++;
        if (expQ.size() == 0) chk(0, "R12 unexpected response", {rspErr, rspData}, 65'd0);
        else begin
          logic [64:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk({rspErr, rspData} === e, t, {rspErr, rspData}, e);
        end
      end
      prevRsp = rspValid;
    end
  end

  function automatic logic [63:0] mk(input logic wide);
    return wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
  endfunction

  function automatic logic [63:0] refRd(input logic [31:0] a, input logic wide);
    return refMem.exists(a) ? (refMem[a] & mk(wide)) : 64'b0;
  endfunction

  function automatic logic [63:0] dutRaw(input logic [31:0] a);
    return dutMem.exists(a) ? dutMem[a] : 64'b0;
  endfunction

  function automatic logic [63:0] refRaw(input logic [31:0] a);
    return refMem.exists(a) ? refMem[a] : 64'b0;
  endfunction

  task automatic preload(input logic [31:0] a, input logic wide, input logic [63:0] v);
    dutMem[a] = v & mk(wide);
    refMem[a] = v & mk(wide);
  endtask

  function automatic logic [63:0] refAlu(input logic [2:0] op, input logic wide,
                                         input logic [63:0] o, input logic [63:0] a);
    logic [63:0] m, r;
    bit lts, ltu;
    m = mk(wide);
    ltu = (o & m) < (a & m);
    lts = wide ? ($signed(o) < $signed(a)) : ($signed(o[31:0]) < $signed(a[31:0]));
    case (op)
      3'd0: r = o + a;
      3'd1: r = o ^ a;
      3'd2: r = o | a;
      3'd3: r = o & a;
      3'd4: r = ltu ? a : o;
      3'd5: r = lts ? a : o;
      3'd6: r = ltu ? o : a;
      default: r = lts ? o : a;
    endcase
    return r & m;
  endfunction

  task automatic runOp(input logic st, input logic wide, input logic [4:0] fc,
                       input logic [31:0] ea, input logic [63:0] a, input logic [63:0] b,
                       input string tag);
    logic [63:0] m, sgn, o, o2, d;
    logic [31:0] sz;
    logic e;
    m = mk(wide);
    sz = wide ? 32'd8 : 32'd4;
    sgn = wide ? 64'h8000_0000_0000_0000 : 64'h8000_0000;
    d = 0; e = 0;
    o = refRd(ea, wide);
    if (fc < 5'd8) begin
      refMem[ea] = refAlu(fc[2:0], wide, o, a);
      d = st ? 64'b0 : o;
    end else if (!st && fc == 5'd8) begin
      refMem[ea] = a & m; d = o;
    end else if (!st && fc == 5'd16) begin
      if (o != (a & m)) refMem[ea] = b & m;
      d = o;
    end else if (!st && (fc == 5'd24 || fc == 5'd25)) begin
      o2 = refRd(ea + sz, wide);
      if ((fc == 5'd24) ? (o != o2) : (o == o2)) begin
        refMem[ea] = (o + 1) & m; d = o;
      end else d = sgn;
    end else if (!st && fc == 5'd28) begin
      o2 = refRd(ea - sz, wide);
      if (o != o2) begin refMem[ea] = (o - 1) & m; d = o; end
      else d = sgn;
    end else if (st && fc == 5'd24) begin
      o2 = refRd(ea + sz, wide);
      if (o == o2) begin refMem[ea] = a & m; refMem[ea + sz] = a & m; end
    end else e = 1;
    expQ.push_back({e, d});
    tagQ.push_back(tag);
    @(negedge clk);
    reqValid = 1; reqStore = st; reqWide = wide; reqFunc = fc;
    reqAddr = ea; reqOpA = a; reqOpB = b;
    @(negedge clk);
    accepted++;
    reqValid = 0;
    chk(reqReady == 1'b0, "R1 ready low while busy", {64'b0, reqReady}, 65'd0);
    while (expQ.size() != 0) @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready after completion", {64'b0, reqReady}, 65'd1);
    for (int k = -1; k <= 1; k++) begin
      logic [31:0] ad;
      ad = ea + sz * k;
      chk(dutRaw(ad) === refRaw(ad), {tag, " memory"}, {1'b0, dutRaw(ad)}, {1'b0, refRaw(ad)});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady === 1'b1, "R1 reset ready", {64'b0, reqReady}, 65'd1);
    chk(rspValid === 1'b0, "R1 reset rspValid", {64'b0, rspValid}, 65'd0);
    // R2 64-bit fetching ops on a negative and a positive word
    for (int op = 0; op < 8; op++) begin
      preload(32'h100, 1, 64'hFFFF_FFFF_FFFF_FFF0);
      runOp(0, 1, 5'(op), 32'h100, 64'h10, 0, "R2 fetch wide neg");
      preload(32'h100, 1, 64'h0000_0000_0000_1234);
      runOp(0, 1, 5'(op), 32'h100, 64'h8000_0000_0000_0001, 0, "R2 fetch wide pos");
    end
    // R4 32-bit fetching ops, sign from bit 31, wraparound
    for (int op = 0; op < 8; op++) begin
      preload(32'h404, 0, 64'h8000_0001);
      runOp(0, 0, 5'(op), 32'h404, 64'hDEAD_0000_7FFF_FFFF, 0, "R4 fetch narrow");
    end
    // R3 swap
    preload(32'h140, 1, 64'h1111);
    runOp(0, 1, 5'd8, 32'h140, 64'hABCD_EF01_2345_6789, 0, "R3 swap wide");
    preload(32'h420, 0, 64'h55);
    runOp(0, 0, 5'd8, 32'h420, 64'hFFFF_FFFF_1234_5678, 0, "R3 swap narrow");
    // R5 compare-and-swap-not-equal
    preload(32'h160, 1, 64'h77);
    runOp(0, 1, 5'd16, 32'h160, 64'h77, 64'h99, "R5 casne equal");
    runOp(0, 1, 5'd16, 32'h160, 64'h78, 64'h99, "R5 casne differ");
    // R6 increment bounded
    preload(32'h180, 1, 64'h5); preload(32'h188, 1, 64'h9);
    runOp(0, 1, 5'd24, 32'h180, 0, 0, "R6 incb differ");
    preload(32'h180, 1, 64'h9);
    runOp(0, 1, 5'd24, 32'h180, 0, 0, "R6 incb equal");
    preload(32'h440, 0, 64'h3); preload(32'h444, 0, 64'h3);
    runOp(0, 0, 5'd24, 32'h440, 0, 0, "R6 incb narrow fail");
    // R7 increment equal
    preload(32'h1A0, 1, 64'hFFFF_FFFF_FFFF_FFFF); preload(32'h1A8, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    runOp(0, 1, 5'd25, 32'h1A0, 0, 0, "R7 ince equal wrap");
    runOp(0, 1, 5'd25, 32'h1A0, 0, 0, "R7 ince differ");
    // R8 decrement bounded
    preload(32'h1C0, 1, 64'h4); preload(32'h1C8, 1, 64'h7);
    runOp(0, 1, 5'd28, 32'h1C8, 0, 0, "R8 decb differ");
    preload(32'h1C8, 1, 64'h4);
    runOp(0, 1, 5'd28, 32'h1C8, 0, 0, "R8 decb equal");
    preload(32'h460, 0, 64'h1); preload(32'h464, 0, 64'h0);
    runOp(0, 0, 5'd28, 32'h464, 0, 0, "R8 decb narrow wrap");
    // R9 store ops
    for (int op = 0; op < 8; op++) begin
      preload(32'h200, 1, 64'h8000_0000_0000_00F0);
      runOp(1, 1, 5'(op), 32'h200, 64'h0F, 0, "R9 store wide");
      preload(32'h480, 0, 64'hFFFF_FF00);
      runOp(1, 0, 5'(op), 32'h480, 64'h0000_0100, 0, "R9 store narrow");
    end
    // R10 twin store
    preload(32'h220, 1, 64'h42); preload(32'h228, 1, 64'h42);
    runOp(1, 1, 5'd24, 32'h220, 64'hCAFE, 0, "R10 twin equal");
    preload(32'h228, 1, 64'h43);
    runOp(1, 1, 5'd24, 32'h220, 64'hBEEF, 0, "R10 twin differ");
    // R11 unknown codes
    preload(32'h240, 1, 64'h1234);
    runOp(0, 1, 5'd9, 32'h240, 64'h1, 64'h2, "R11 bad fetch code");
    runOp(1, 1, 5'd16, 32'h240, 64'h1, 64'h2, "R11 bad store code");
    runOp(1, 1, 5'd8, 32'h240, 64'h1, 64'h2, "R11 store swap code");
    runOp(0, 1, 5'd29, 32'h240, 64'h1, 64'h2, "R11 bad high code");
    // R12 one pulse per request
    repeat (3) @(negedge clk);
    chk(pulses == accepted, "R12 pulse count", 65'(pulses), 65'(accepted));
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule